// File: doc/BRIEF.md
# Buffered Dual-Register PWM Timer

This block is a 16-bit up-counting timer with two compare channels that produce pulse-width modulated outputs. The counter runs from zero to a programmable modulo value and wraps. An optional power-of-two prescaler divides the clock, and code zero bypasses it. Each channel can change its pin when the counter reaches the channel's compare value. Each channel can also drive the pin to the pulse level at every wrap. Together these give one PWM waveform per channel.

Channel 0 has a linked mode in which both compare registers serve one output on the channel 0 pin. Software writes the next pulse width into the register that is not in use. The timer switches to that register only when the counter wraps, so the waveform never shows a half-updated period. The register written most recently is the one chosen at each wrap. While the channels are linked, the channel 1 pin is held low and a flag tells the surrounding logic that the pin is free for general-purpose use.

All configuration goes through one word-wide write port. Address 0 is the timer control, 1 the modulo, 2 and 3 the channel 0 and channel 1 configuration, 4 and 5 the channel 0 and channel 1 compare values.

Top module: `pwm_pair_timer`

## Requirements
- R1: The counter advances once per tick from 0 to the modulo value and then wraps to 0. A period is modulo+1 ticks. `ovf` is high for exactly one clock, in the cycle after the wrap, and it appears once per period.
- R2: Timer control bits [3:2] hold a prescale code n. A tick occurs every 2^n clocks, and code 0 ticks on every clock. The spacing of `ovf` pulses is therefore (modulo+1)·2^n clocks.
- R3: Timer control bit 0 set halts the counter and the prescaler: no tick, no `ovf`, and no pin change. Writing timer control with bit 1 set clears the counter and the prescaler on that write. The next `ovf` then follows modulo+1 ticks later.
- R4: Channel configuration bits [3:2] select the compare action when the counter reaches the compare value: 00 none, 01 toggle, 10 drive low, 11 drive high. When a compare and a wrap fall on the same tick, the compare action takes priority.
- R5: Channel configuration bit 4 enables the overflow action. At each wrap the pin is driven to the complement of the compare level. The active pulse therefore lasts min(compare, modulo+1) ticks: a compare of 0 gives 0% and a compare above the modulo gives 100%.
- R6: Channel configuration bits [1:0] select the mode: 00 off with the pin low, 01 unbuffered using the channel's own compare value, and 10 on channel 0 only, which links both channels.
- R7: When channel 0 enters linked mode, the channel 0 compare value sets the pulse width first.
- R8: In linked mode, a write to the compare register that is not in use changes nothing in the current period. At every wrap, the compare register written most recently becomes the one in use. A write that lands on the wrap clock counts for the following wrap.
- R9: In linked mode, a write to the compare register in use takes effect at once, within the current period.
- R10: While linked, `pwm1_out` stays low and `pin1_free` is high. Writes to the channel 1 configuration have no effect on either pin.
- R11: After reset both pins, `ovf` and `pin1_free` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 modulo, 2/3 channel config, 4/5 compare) |
| wr_data | input | 16 | Write data word |
| pwm0_out | output | 1 | Channel 0 pin, buffered PWM output when linked |
| pwm1_out | output | 1 | Channel 1 pin, held low when linked |
| pin1_free | output | 1 | High while the channel 1 pin is released |
| ovf | output | 1 | One-clock pulse after each counter wrap |

## Verification
Two events can fall on the same clock: a write into a compare register and the counter wrap that swaps the active register. The bench provokes this by timing a channel 0 write to land exactly on the wrap edge while channel 1 is in use. It then checks that the next period still uses channel 1's width and that the new width shows up only one period later. A compare match can also coincide with the wrap, when the compare value is 0. The sweep over every compare value from 0 to modulo+2 judges this case by the measured active time, which must be 0 there and must equal the full period when the compare value is above the modulo.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_LINKED = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef struct packed {
    logic  tov;
    act_e  act;
    mode_e mode;
  } chan_cfg_t;

  localparam int unsigned CFG_W   = 5;
  localparam int unsigned NUM_CH  = 2;

  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_MOD   = 1;
  localparam int unsigned A_CFG0  = 2;
  localparam int unsigned A_CFG1  = 3;
  localparam int unsigned A_CMP0  = 4;
  localparam int unsigned A_CMP1  = 5;

  localparam int unsigned BIT_HALT = 0;
  localparam int unsigned BIT_CLR  = 1;
  localparam int unsigned DIV_LSB  = 2;

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  output logic                          halt_o,
  output logic [DIV_W-1:0]              div_o,
  output logic                          clr_o,
  output logic [CNT_W-1:0]              mod_o,
  output chan_cfg_t [NUM_CH-1:0]        cfg_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic [NUM_CH-1:0]             wr_cmp_o,
  output logic                          link_start_o
);

  logic       hit_ctrl, hit_mod, hit_cfg0;
  chan_cfg_t  new_cfg;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign hit_mod  = wr_en && (wr_addr == ADDR_W'(A_MOD));
  assign hit_cfg0 = wr_en && (wr_addr == ADDR_W'(A_CFG0));
  assign new_cfg  = chan_cfg_t'(wr_data[CFG_W-1:0]);

  assign clr_o        = hit_ctrl && wr_data[BIT_CLR];
  assign link_start_o = hit_cfg0 && (new_cfg.mode == MODE_LINKED) &&
                        (cfg_o[0].mode != MODE_LINKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_o <= 1'b0;
      div_o  <= '0;
      mod_o  <= '1;
    end else begin
      if (hit_ctrl) begin
        halt_o <= wr_data[BIT_HALT];
        div_o  <= wr_data[DIV_LSB +: DIV_W];
      end
      if (hit_mod) mod_o <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan_regs
    logic hit_cfg, hit_cmp;
    assign hit_cfg     = wr_en && (wr_addr == ADDR_W'(A_CFG0 + c));
    assign hit_cmp     = wr_en && (wr_addr == ADDR_W'(A_CMP0 + c));
    assign wr_cmp_o[c] = hit_cmp;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[c] <= '0;
        cmp_o[c] <= '0;
      end else begin
        if (hit_cfg) cfg_o[c] <= new_cfg;
        if (hit_cmp) cmp_o[c] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pwmt_count.sv
module pwmt_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [DIV_W-1:0] div,
  input  logic             clr,
  input  logic [CNT_W-1:0] mod,
  output logic             tick_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             ovf_o
);

  localparam int unsigned PSC_W = (1 << DIV_W) - 1;

  logic [PSC_W-1:0] psc_q, mask;
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  always_comb begin
    for (int i = 0; i < PSC_W; i++) mask[i] = (i < int'(div));
  end

  assign tick_o = !halt && (&(psc_q | ~mask));
  assign at_top = (cnt_q >= mod);
  assign nxt_o  = at_top ? '0 : cnt_q + 1'b1;
  assign wrap_o = tick_o && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= wrap_o && !clr;
      if (clr) begin
        psc_q <= '0;
        cnt_q <= '0;
      end else begin
        if (!halt) psc_q <= psc_q + 1'b1;
        if (tick_o) cnt_q <= nxt_o;
      end
    end
  end

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_q == '0)); // R1
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr) |=> $stable(cnt_q)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && psc_q == '0)); // R3

endmodule

// File: rtl/pwmt_bufsel.sv
module pwmt_bufsel
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          linked,
  input  logic                          link_start,
  input  logic [NUM_CH-1:0]             wr_cmp,
  input  logic                          wrap,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp,
  output logic [CNT_W-1:0]              sel_cmp_o
);

  logic last_q;
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (link_start) begin
      last_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (wr_cmp[1])      last_q <= 1'b1;
      else if (wr_cmp[0]) last_q <= 1'b0;
      if (wrap)           act_q  <= last_q;
    end
  end

  assign sel_cmp_o = (linked && act_q) ? cmp[1] : cmp[0];

  AST_SWAP_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !link_start) |=> $stable(act_q)); // R8
  AST_LINK_STARTS_CH0: assert property (@(posedge clk) disable iff (rst)
    link_start |=> (!act_q && !last_q)); // R7

endmodule

// File: rtl/pwmt_pin.sv
module pwmt_pin
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cmp,
  input  chan_cfg_t        cfg,
  output logic             pin_o
);

  logic match;
  logic cmp_level;
  logic ovf_level;

  assign match = tick && (nxt == cmp);

  always_comb begin
    unique case (cfg.act)
      ACT_SET:   begin cmp_level = 1'b1;   ovf_level = 1'b0;   end
      ACT_CLEAR: begin cmp_level = 1'b0;   ovf_level = 1'b1;   end
      ACT_NONE:  begin cmp_level = pin_o;  ovf_level = ~pin_o; end
      default:   begin cmp_level = ~pin_o; ovf_level = ~pin_o; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pin_o <= 1'b0;
    end else if (match) begin
      pin_o <= cmp_level;
    end else if (wrap && cfg.tov) begin
      pin_o <= ovf_level;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pin_o); // R6
  AST_COMPARE_WINS: assert property (@(posedge clk) disable iff (rst)
    (en && match && cfg.act == ACT_CLEAR) |=> !pin_o); // R4
  AST_TOV_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (en && wrap && !match && cfg.tov && cfg.act == ACT_SET) |=> !pin_o); // R5

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm0_out,
  output logic              pwm1_out,
  output logic              pin1_free,
  output logic              ovf
);

  logic                         halt, clr, link_start;
  logic [DIV_W-1:0]             div;
  logic [CNT_W-1:0]             mod, nxt, sel_cmp;
  chan_cfg_t [NUM_CH-1:0]       cfg;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp, cmp_use;
  logic [NUM_CH-1:0]            wr_cmp, ch_en, pins;
  logic                         tick, wrap, linked;

  pwmt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .halt_o(halt), .div_o(div), .clr_o(clr), .mod_o(mod), .cfg_o(cfg),
    .cmp_o(cmp), .wr_cmp_o(wr_cmp), .link_start_o(link_start)
  );

  pwmt_count #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_count (
    .clk(clk), .rst(rst), .halt(halt), .div(div), .clr(clr), .mod(mod),
    .tick_o(tick), .wrap_o(wrap), .nxt_o(nxt), .ovf_o(ovf)
  );

  assign linked = (cfg[0].mode == MODE_LINKED);

  pwmt_bufsel #(.CNT_W(CNT_W)) u_bufsel (
    .clk(clk), .rst(rst), .linked(linked), .link_start(link_start),
    .wr_cmp(wr_cmp), .wrap(wrap), .cmp(cmp), .sel_cmp_o(sel_cmp)
  );

  assign ch_en[0]   = (cfg[0].mode != MODE_OFF);
  assign ch_en[1]   = !linked && (cfg[1].mode != MODE_OFF);
  assign cmp_use[0] = sel_cmp;
  assign cmp_use[1] = cmp[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
    pwmt_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst(rst), .en(ch_en[c]), .tick(tick), .wrap(wrap),
      .nxt(nxt), .cmp(cmp_use[c]), .cfg(cfg[c]), .pin_o(pins[c])
    );
  end

  assign pwm0_out  = pins[0];
  assign pwm1_out  = pins[1];
  assign pin1_free = linked;

  AST_PIN1_RELEASED: assert property (@(posedge clk) disable iff (rst)
    linked |=> !pwm1_out); // R10

endmodule

// File: tb/tb_pwm_pair_timer.sv
module tb_pwm_pair_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm0_out, pwm1_out, pin1_free, ovf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  pwm_pair_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm0_out(pwm0_out), .pwm1_out(pwm1_out), .pin1_free(pin1_free), .ovf(ovf)
  );

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Waits for an ovf sample, then samples n clocks starting there.
  // Optionally issues one write at sample index wr_at (captured on the
  // following rising edge).
  task automatic measure(input int n, input int wr_at, input int a, input int d,
                         output int hi0, output int hi1, output int nov,
                         output int waited);
    hi0 = 0; hi1 = 0; nov = 0; waited = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (!ovf) begin
      @(negedge clk);
      waited++;
    end
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (k == wr_at + 1) wr_en = 1'b0;
      hi0 += int'(pwm0_out);
      hi1 += int'(pwm1_out);
      nov += int'(ovf);
      if (k == wr_at) begin
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h0, h1, nv, wt, cnt;
    logic p0;

    repeat (3) @(negedge clk);
    check(pwm0_out == 1'b0, "R11 pwm0 reset", int'(pwm0_out), 0);
    check(pwm1_out == 1'b0, "R11 pwm1 reset", int'(pwm1_out), 0);
    check(pin1_free == 1'b0, "R11 pin1_free reset", int'(pin1_free), 0);
    check(ovf == 1'b0, "R11 ovf reset", int'(ovf), 0);
    rst = 1'b0;

    // Unbuffered sweep, modulo 7, no prescale: ch0 clear-on-compare,
    // ch1 set-on-compare, both with overflow action.
    wr(1, 7);
    wr(2, 'h19);
    wr(3, 'h1D);
    wr(0, 'h2);
    for (int v = 0; v <= 9; v++) begin
      wr(4, v);
      wr(5, 9 - v);
      measure(8, -1, 0, 0, h0, h1, nv, wt);
      measure(8, -1, 0, 0, h0, h1, nv, wt);
      check(h0 == imin(v, 8), "R5 ch0 high time", h0, imin(v, 8));
      check((8 - h1) == imin(9 - v, 8), "R4 ch1 low time", 8 - h1, imin(9 - v, 8));
      check(nv == 1, "R1 one ovf per period", nv, 1);
      check(wt == 1, "R1 period length", wt, 1);
    end

    // Prescaler sweep, modulo 3, compare 2.
    wr(1, 3);
    wr(4, 2);
    for (int n = 1; n <= 3; n++) begin
      wr(0, n << 2);
      measure(4 << n, -1, 0, 0, h0, h1, nv, wt);
      measure(4 << n, -1, 0, 0, h0, h1, nv, wt);
      check(h0 == (2 << n), "R2 scaled high time", h0, 2 << n);
      check(nv == 1, "R2 single ovf pulse", nv, 1);
      check(wt == 1, "R2 ovf spacing", wt, 1);
    end

    // Halt and clear.
    wr(0, 0);
    wr(1, 7);
    measure(8, -1, 0, 0, h0, h1, nv, wt);
    wr(0, 1);
    @(negedge clk);
    p0 = pwm0_out;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cnt += int'(ovf) + int'(pwm0_out != p0);
    end
    check(cnt == 0, "R3 halt freezes", cnt, 0);
    wr(0, 2);
    cnt = 0;
    while (!ovf && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == 8, "R3 clear restarts period", cnt, 8);

    // Linked mode, modulo 7.
    wr(4, 2);
    wr(5, 6);
    wr(2, 'h1A);
    measure(8, -1, 0, 0, h0, h1, nv, wt);
    measure(8, -1, 0, 0, h0, h1, nv, wt);
    check(h0 == 2, "R7 ch0 first after link", h0, 2);
    check(h1 == 0, "R10 pin1 low when linked", h1, 0);
    check(pin1_free == 1'b1, "R10 pin1_free set", int'(pin1_free), 1);
    measure(8, 3, 5, 5, h0, h1, nv, wt);
    check(h0 == 2, "R8 inactive write deferred", h0, 2);
    measure(8, 7, 4, 4, h0, h1, nv, wt);
    check(h0 == 5, "R8 swap at overflow", h0, 5);
    measure(8, -1, 0, 0, h0, h1, nv, wt);
    check(h0 == 5, "R8 write on wrap clock counts next", h0, 5);
    measure(8, 0, 4, 3, h0, h1, nv, wt);
    check(h0 == 3, "R9 active write immediate", h0, 3);
    measure(8, 2, 3, 'h1D, h0, h1, nv, wt);
    check(h0 == 3, "R8 last written stays", h0, 3);
    check(h1 == 0, "R10 ch1 config ignored", h1, 0);
    wr(2, 'h19);
    check(pin1_free == 1'b0, "R6 unlink releases flag", int'(pin1_free), 0);
    wr(2, 'h0);
    @(negedge clk);
    check(pwm0_out == 1'b0, "R6 mode off pin low", int'(pwm0_out), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule